// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block lets an 8-bit host processor reach a bank of up to 256 internal registers through whichever of three bus styles the board provides. A single strap-like input, the address-latch pin, picks the style: held high it gives a Motorola-style bus with a read/write direction line and a data strobe. Held low it gives an Intel-style bus with separate read and write strobes and a dedicated address bus. Any transition on the pin switches the block to an Intel-style multiplexed bus, where the address travels on the data lines and is latched when the pin falls. That switch holds until the next hardware reset.

All host pins are brought into the internal clock domain through a synchronizer chain. Each host access then becomes one single-cycle strobe toward the register bank: a write strobe with address and write data, or a read strobe with address. The register bank returns read data combinationally, and the block drives it onto the host data bus only while a read is in progress. In Motorola mode the write-strobe pin carries the read/write direction (1 = read) and the read-strobe pin carries the active-low data strobe.

Top module: `hbus_if`

## Requirements
- R1: While reset is asserted and after it is released with the bus idle (chip select high), no write strobe, no read strobe and no data output enable is active.
- R2: With the latch pin steady since reset, `mode_o` reads 1 (Motorola style) when the pin is high and 0 (Intel non-multiplexed) when it is low.
- R3: Any rising or falling edge on the latch pin after reset sets `mode_o` to 2 (multiplexed). It then stays 2 whatever the pin does, until a hardware reset returns it to the level-selected mode.
- R4: In modes 0 and 2, a rising edge of the write strobe pin while chip select is low gives exactly one `reg_we_o` pulse. The pulse carries the access address and the host write data.
- R5: In modes 0 and 2, a falling edge of the read strobe pin while chip select is low gives exactly one `reg_re_o` pulse with the access address. `data_o` then equals `reg_rdata_i` for that address, with `data_oe_o` high while chip select and the read strobe stay low.
- R6: In mode 1, a rising edge of the data strobe while chip select is low and the direction line is low (write) gives exactly one `reg_we_o` pulse with the address pins and the write data.
- R7: In mode 1, a falling edge of the data strobe while chip select is low and the direction line is high (read) gives exactly one `reg_re_o` pulse, and `data_oe_o` is high with the read data on `data_o`.
- R8: In mode 2, the value on the data lines at the falling edge of the latch pin is the address used by the following accesses, and the address pins are ignored.
- R9: With chip select high, strobe activity gives no register strobe and leaves `data_oe_o` low.
- R10: `reg_we_o` and `reg_re_o` are never high together. `reg_addr_o` changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low hardware reset |
| ale_i | input | 1 | Address-latch / bus style pin |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wr_n_i | input | 1 | Write strobe (Intel) or read/write direction (Motorola, 1 = read) |
| addr_i | input | AW | Address bus (non-multiplexed modes) |
| data_i | input | DW | Host data in; carries the address in mode 2 |
| data_o | output | DW | Host read data |
| data_oe_o | output | 1 | Enable for driving `data_o` onto the host bus |
| mode_o | output | 2 | Bus style: 0 Intel, 1 Motorola, 2 multiplexed |
| reg_addr_o | output | AW | Register address of the last access |
| reg_wdata_o | output | DW | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | DW | Register read data for `reg_addr_o` |

## Verification
The bench builds the block with its default 8-bit address and data widths and a two-stage synchronizer. At that size it can write and read back every one of the 256 register addresses in each of the three bus styles. Reads use a bench-side register model whose value is an arithmetic function of the address. The bench also resets with the pin high and low and locks multiplexed mode with a single pulse. It holds the pin high afterwards to show that the lock sticks, and drives strobes with chip select high.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    HB_INTEL = 2'd0,
    HB_MOTO  = 2'd1,
    HB_MUX   = 2'd2
  } hb_mode_e;

  // Bus style from lock state and the synchronized latch-pin level.
  function automatic hb_mode_e mode_pick(input logic locked, input logic lvl);
    if (locked) return HB_MUX;
    return lvl ? HB_MOTO : HB_INTEL;
  endfunction

  // Read qualifier: ctl_a is wr_n (Intel) or direction (Motorola),
  // ctl_b is rd_n (Intel) or data strobe (Motorola).
  function automatic logic rd_qual(input hb_mode_e m, input logic ctl_a,
                                   input logic ctl_b);
    if (m == HB_MOTO) return ~ctl_b & ctl_a;
    return ~ctl_b;
  endfunction

  // Write completion: deasserting edge of the relevant strobe.
  function automatic logic wr_done(input hb_mode_e m,
                                   input logic a, input logic a_p,
                                   input logic b, input logic b_p);
    if (m == HB_MOTO) return b & ~b_p & ~a;
    return a & ~a_p;
  endfunction

  // Read start: asserting edge of the relevant strobe.
  function automatic logic rd_start(input hb_mode_e m,
                                    input logic a,
                                    input logic b, input logic b_p);
    if (m == HB_MOTO) return ~b & b_p & a;
    return ~b & b_p;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(DEPTH*W){RST_BIT}};
    else        chain <= {chain[DEPTH-2:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/hbus_mode.sv
module hbus_mode
  import hbus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  input  logic     lvl_prev,
  output hb_mode_e mode,
  output logic     edge_seen,
  output logic     fall_seen
);
  localparam int FILL = STAGES + 1;
  localparam int WW   = $clog2(FILL + 1);

  logic [WW-1:0] warm;
  logic          armed;
  logic          locked;

  // Edges are trusted only once the synchronizer chain holds real samples.
  assign armed     = (warm == WW'(FILL));
  assign edge_seen = armed & (lvl ^ lvl_prev);
  assign fall_seen = armed & ~lvl & lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm   <= '0;
      locked <= 1'b0;
    end else begin
      if (!armed)    warm   <= warm + 1'b1;
      if (edge_seen) locked <= 1'b1;
    end
  end

  assign mode = mode_pick(locked, lvl);
endmodule

// File: rtl/hbus_access.sv
module hbus_access
  import hbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hb_mode_e      mode,
  input  logic          sel_n,
  input  logic          ca,
  input  logic          ca_p,
  input  logic          cb,
  input  logic          cb_p,
  input  logic          ale_fall,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          sel_act,
  output logic          wr_evt,
  output logic          rd_evt,
  output logic          oe,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          we_q,
  output logic          re_q
);
  logic [AW-1:0] mux_addr;
  logic [AW-1:0] cur_addr;

  assign sel_act  = ~sel_n;
  assign wr_evt   = sel_act & wr_done(mode, ca, ca_p, cb, cb_p);
  assign rd_evt   = sel_act & rd_start(mode, ca, cb, cb_p);
  assign oe       = sel_act & rd_qual(mode, ca, cb);
  assign cur_addr = (mode == HB_MUX) ? mux_addr : addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_addr <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      if (ale_fall)         mux_addr <= AW'(data_i);
      if (wr_evt | rd_evt)  addr_q   <= cur_addr;
      if (wr_evt)           wdata_q  <= data_i;
      we_q <= wr_evt;
      re_q <= rd_evt;
    end
  end
endmodule

// File: rtl/hbus_if.sv
module hbus_if
  import hbus_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_i,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [1:0]    mode_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int CW = 3;

  logic          ale_s, ale_p;
  logic [CW-1:0] ctl_s, ctl_p;
  hb_mode_e      mode;
  logic          ale_edge, ale_fall;
  logic          sel_act, wr_evt, rd_evt;

  hbus_sync #(.W(1), .STAGES(STAGES), .RST_BIT(1'b0)) u_ale_sync (
    .clk(clk), .rst_n(rst_n), .d(ale_i), .q(ale_s), .q_prev(ale_p)
  );

  hbus_sync #(.W(CW), .STAGES(STAGES), .RST_BIT(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n_i, wr_n_i, rd_n_i}),
    .q(ctl_s), .q_prev(ctl_p)
  );

  hbus_mode #(.STAGES(STAGES)) u_mode (
    .clk(clk), .rst_n(rst_n), .lvl(ale_s), .lvl_prev(ale_p),
    .mode(mode), .edge_seen(ale_edge), .fall_seen(ale_fall)
  );

  hbus_access #(.AW(AW), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sel_n(ctl_s[2]),
    .ca(ctl_s[1]), .ca_p(ctl_p[1]),
    .cb(ctl_s[0]), .cb_p(ctl_p[0]),
    .ale_fall(ale_fall), .addr_i(addr_i), .data_i(data_i),
    .sel_act(sel_act), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .oe(data_oe_o), .addr_q(reg_addr_o), .wdata_q(reg_wdata_o),
    .we_q(reg_we_o), .re_q(reg_re_o)
  );

  logic unused_cs_prev;
  assign unused_cs_prev = ctl_p[2];

  assign mode_o = mode;
  assign data_o = reg_rdata_i;
endmodule

// File: rtl/hbus_if_chk.sv
module hbus_if_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          we,
  input logic          re,
  input logic          oe,
  input logic [AW-1:0] addr,
  input logic          sel_act,
  input logic          ale_edge
);
  a_r3_mux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode == 2'd2));

  a_r3_edge_locks: assert property (@(posedge clk) disable iff (!rst_n)
    ale_edge |=> (mode == 2'd2));

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  a_r5_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> !re);

  a_r9_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> sel_act);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

  a_r10_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> (we || re));
endmodule

bind hbus_if hbus_if_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_o), .we(reg_we_o), .re(reg_re_o),
  .oe(data_oe_o), .addr(reg_addr_o), .sel_act(sel_act), .ale_edge(ale_edge)
);

// File: tb/sim_hbus_if.sv
module sim_hbus_if;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dat = '0;
  logic [DW-1:0] data_o, reg_wdata, reg_rdata;
  logic          data_oe, reg_we, reg_re;
  logic [1:0]    mode;
  logic [AW-1:0] reg_addr;

  int n_chk = 0, n_bad = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [AW-1:0] we_a, re_a;
  logic [DW-1:0] we_d;
  bit   reported = 0;

  always #10 clk = ~clk;   // 50 MHz

  // Bench register model: value is an arithmetic function of the address.
  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction
  assign reg_rdata = model(reg_addr);

  hbus_if u0 (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
    .wr_n_i(wr_n), .addr_i(addr), .data_i(dat), .data_o(data_o),
    .data_oe_o(data_oe), .mode_o(mode), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_rdata_i(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_we) begin we_cnt++; we_a = reg_addr; we_d = reg_wdata; end
    if (reg_re) begin re_cnt++; re_a = reg_addr; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset(input logic ale_lvl);
    ale = ale_lvl; cs_n = 1; rd_n = 1; wr_n = 1;
    rst_n = 0;
    tick(3);
    chk(!reg_we && !reg_re && !data_oe, "R1 in reset", {reg_we, reg_re, data_oe}, 0);
    rst_n = 1;
    tick(8);
    chk(!reg_we && !reg_re && !data_oe, "R1 after reset", {reg_we, reg_re, data_oe}, 0);
    chk(mode == (ale_lvl ? 2'd1 : 2'd0), "R2 mode by level", mode, ale_lvl ? 1 : 0);
  endtask

  // Intel-style write (modes 0 and 2): address already presented or latched.
  task automatic i_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    int w0 = we_cnt, r0 = re_cnt;
    dat = d;
    cs_n = 0; tick(4);
    wr_n = 0; tick(4);
    wr_n = 1; tick(4);
    cs_n = 1; tick(4);
    chk(we_cnt == w0 + 1 && re_cnt == r0, {req, " one write strobe"}, we_cnt - w0, 1);
    chk(we_a == a, {req, " write address"}, we_a, a);
    chk(we_d == d, {req, " write data"}, we_d, d);
  endtask

  task automatic i_read(input logic [AW-1:0] a, input string req);
    int w0 = we_cnt, r0 = re_cnt;
    cs_n = 0; tick(4);
    rd_n = 0; tick(6);
    chk(data_oe == 1, {req, " oe during read"}, data_oe, 1);
    chk(data_o == model(a), {req, " read data"}, data_o, model(a));
    rd_n = 1; tick(4);
    cs_n = 1; tick(4);
    chk(re_cnt == r0 + 1 && we_cnt == w0 && re_a == a, {req, " one read strobe"}, re_a, a);
    chk(data_oe == 0, {req, " oe off after read"}, data_oe, 0);
  endtask

  // Motorola style: wr_n carries direction (1 = read), rd_n carries data strobe.
  task automatic m_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0 = we_cnt, r0 = re_cnt;
    addr = a; dat = d; wr_n = 0; tick(4);
    cs_n = 0; tick(4);
    rd_n = 0; tick(4);
    rd_n = 1; tick(4);
    cs_n = 1; tick(2);
    wr_n = 1; tick(4);
    chk(we_cnt == w0 + 1 && re_cnt == r0, "R6 one write strobe", we_cnt - w0, 1);
    chk(we_a == a && we_d == d, "R6 write address/data", {we_a, we_d}, {a, d});
  endtask

  task automatic m_read(input logic [AW-1:0] a);
    int w0 = we_cnt, r0 = re_cnt;
    addr = a; wr_n = 1; tick(2);
    cs_n = 0; tick(4);
    rd_n = 0; tick(6);
    chk(data_oe == 1 && data_o == model(a), "R7 read data with oe", data_o, model(a));
    rd_n = 1; tick(4);
    cs_n = 1; tick(4);
    chk(re_cnt == r0 + 1 && we_cnt == w0 && re_a == a, "R7 one read strobe", re_a, a);
    chk(data_oe == 0, "R7 oe off after read", data_oe, 0);
  endtask

  task automatic mux_latch(input logic [AW-1:0] a);
    dat = a; addr = ~a;
    ale = 1; tick(4);
    ale = 0; tick(4);
  endtask

  task automatic idle_strobes(input string req);
    int w0 = we_cnt, r0 = re_cnt;
    bit oe_seen = 0;
    cs_n = 1;
    for (int k = 0; k < 4; k++) begin
      rd_n = 0; tick(3); oe_seen |= data_oe; tick(3);
      rd_n = 1; tick(3);
      wr_n = 0; tick(3);
      wr_n = 1; tick(3);
    end
    tick(4);
    chk(we_cnt == w0 && re_cnt == r0, {req, " no strobe with CS high"},
        (we_cnt - w0) + (re_cnt - r0), 0);
    chk(!oe_seen, {req, " no oe with CS high"}, oe_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
  end

  initial begin
    // Motorola style
    do_reset(1'b1);
    for (int a = 0; a < 256; a++) begin
      m_write(AW'(a), DW'(a * 7 + 1));
      m_read(AW'(a));
    end
    idle_strobes("R9 mode1");
    chk(mode == 2'd1, "R2 Motorola mode held", mode, 1);

    // Intel non-multiplexed
    do_reset(1'b0);
    for (int a = 0; a < 256; a++) begin
      addr = AW'(a);
      i_write(AW'(a), DW'(a * 13 + 5), "R4");
      i_read(AW'(a), "R5");
    end
    idle_strobes("R9 mode0");

    // Lock into multiplexed mode with a single pulse
    ale = 1; tick(8);
    chk(mode == 2'd2, "R3 edge locks mux", mode, 2);
    tick(20);
    chk(mode == 2'd2, "R3 mux sticky with pin high", mode, 2);
    ale = 0; tick(8);
    chk(mode == 2'd2, "R3 mux sticky with pin low", mode, 2);

    for (int a = 0; a < 256; a++) begin
      mux_latch(AW'(a));
      i_write(AW'(a), DW'(a ^ 8'h5A), "R8");
      mux_latch(AW'(255 - a));
      i_read(AW'(255 - a), "R8");
    end
    idle_strobes("R9 mode2");

    // Reset leaves multiplexed mode
    do_reset(1'b0);
    chk(mode == 2'd0, "R3 reset leaves mux", mode, 0);
    do_reset(1'b1);

    summary();
  end
endmodule